// File: doc/BRIEF.md
# Indirect Register Access Port

This block bridges a small bus-mapped register window to an internal register file that the bus cannot reach directly. Software fills a command register with a 6-bit internal address and a read/write select, loads a write-data register when it is writing, and then pulses a start bit. Each rising transition of that start bit launches exactly one internal access. A read leaves the addressed internal word in a read-data register, where the bus picks it up.

The internal file is write-protected out of reset. Writing the unlock word 0xA5000000 to internal address 0 lifts the protection. Writing any other value to address 0 turns it back on. Only addresses 1 through `IMPL_WORDS` hold storage. Every other internal address, address 0 included, reads as zero.

Top module: `ind_reg_port`

## Requirements
- R1: After reset, the four bus registers (command at bus index 0, start at 1, write data at 2, read data at 3) all read zero. The internal file holds zeros and is write-protected.
- R2: The command register keeps the internal address in bits 5:0 and the read select in bit 8, where 1 means read and 0 means write. All other bits are dropped and read back as zero.
- R3: An internal access launches only on a 0-to-1 transition of bit 0 of the start register. Writing 1 while the bit is already 1 launches nothing, and neither does writing 0.
- R4: When protection is off, a write access stores the write-data register in the addressed implemented word (addresses 1..IMPL_WORDS).
- R5: While protection is on, a write access to any nonzero internal address leaves the internal file unchanged.
- R6: A write access to internal address 0 with data 0xA5000000 turns protection off. A write access to address 0 with any other data turns it on.
- R7: A read access loads the read-data register one clock after the edge that sets the start bit, so it is visible on the bus in the cycle after that. The register then holds its value until the next read access, and write accesses leave it alone.
- R8: Internal address 0 and addresses above IMPL_WORDS read as zero. Writes to addresses above IMPL_WORDS change nothing.
- R9: The write-data register reads back the last 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Bus write strobe for the selected register |
| busAddr | input | 2 | Bus register index: 0 command, 1 start, 2 write data, 3 read data |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data of the selected register, combinational |

## Verification
The bench builds the block with IMPL_WORDS set to 5. This brings the whole 64-entry internal address space within reach of full sweeps.

The sweeps run twice, once with protection on and once with it off. They cover the implemented words and the zero-reading holes below and above them in the same pass, and each address gets its own arithmetic pattern. Directed sequences then cover three further cases: a repeated start write, the one-cycle read latency, and relocking through address 0.

// File: rtl/ind_reg_port_pkg.sv
package ind_reg_port_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int RDSEL_BIT = 8;
  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'hA500_0000;

  localparam logic [1:0] REG_CMD   = 2'd0;
  localparam logic [1:0] REG_START = 2'd1;
  localparam logic [1:0] REG_WDATA = 2'd2;
  localparam logic [1:0] REG_RDATA = 2'd3;

  typedef struct packed {
    logic              wdLoad;
    logic              rdGo;
    logic              wrGo;
    logic [ADDR_W-1:0] addr;
  } accStrobe_t;
endpackage

// File: rtl/ind_reg_port_ctrl.sv
module ind_reg_port_ctrl
  import ind_reg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] cmdView,
  output logic [DATA_W-1:0] startView,
  output accStrobe_t        strobe
);
  logic [ADDR_W-1:0] cmdAddr;
  logic              cmdRead;
  logic              startBit;
  logic              startSeen;
  logic              launch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddr   <= '0;
      cmdRead   <= 1'b0;
      startBit  <= 1'b0;
      startSeen <= 1'b0;
    end else begin
      startSeen <= startBit;
      if (busWe && busAddr == REG_CMD) begin
        cmdAddr <= busWdata[ADDR_W-1:0];
        cmdRead <= busWdata[RDSEL_BIT];
      end
      if (busWe && busAddr == REG_START) begin
        startBit <= busWdata[0];
      end
    end
  end

  assign launch = startBit & ~startSeen;

  always_comb begin
    strobe        = '0;
    strobe.wdLoad = busWe && (busAddr == REG_WDATA);
    strobe.rdGo   = launch & cmdRead;
    strobe.wrGo   = launch & ~cmdRead;
    strobe.addr   = cmdAddr;
  end

  always_comb begin
    cmdView                   = '0;
    cmdView[ADDR_W-1:0]       = cmdAddr;
    cmdView[RDSEL_BIT]        = cmdRead;
    startView                 = '0;
    startView[0]              = startBit;
  end

  assert_single_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdGo || strobe.wrGo) |=> !(strobe.rdGo || strobe.wrGo));

  assert_held_start_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(startBit) && startBit) |-> !(strobe.rdGo || strobe.wrGo));

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdGo, strobe.wrGo}));
endmodule

// File: rtl/ind_reg_port_dp.sv
module ind_reg_port_dp
  import ind_reg_port_pkg::*;
#(
  parameter int IMPL_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] wdataQ,
  output logic [DATA_W-1:0] rdataQ
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMPL_WORDS);

  logic [IMPL_WORDS-1:0][DATA_W-1:0] fileQ;
  logic                              locked;
  logic [DATA_W-1:0]                 readMux;
  logic                              addrZero;

  assign addrZero = (strobe.addr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdataQ <= '0;
    end else if (strobe.wdLoad) begin
      wdataQ <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b1;
    end else if (strobe.wrGo && addrZero) begin
      locked <= (wdataQ != UNLOCK_WORD);
    end
  end

  for (genvar i = 0; i < IMPL_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fileQ[i] <= '0;
      end else if (strobe.wrGo && !locked && strobe.addr == ADDR_W'(i + 1)) begin
        fileQ[i] <= wdataQ;
      end
    end
  end

  always_comb begin
    readMux = '0;
    for (int i = 0; i < IMPL_WORDS; i++) begin
      if (strobe.addr == ADDR_W'(i + 1)) readMux = fileQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.rdGo) begin
      rdataQ <= readMux;
    end
  end

  assert_locked_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && strobe.wrGo && !addrZero) |=> $stable(fileQ));

  assert_unlock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrGo && addrZero && wdataQ == UNLOCK_WORD) |=> !locked);

  assert_relock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrGo && addrZero && wdataQ != UNLOCK_WORD) |=> locked);

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdGo |=> $stable(rdataQ));

  assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdGo && (addrZero || strobe.addr > LAST_ADDR)) |=> (rdataQ == '0));

  assert_hole_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrGo && strobe.addr > LAST_ADDR) |=> $stable(fileQ));
endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port
  import ind_reg_port_pkg::*;
#(
  parameter int IMPL_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  accStrobe_t        strobe;
  logic [DATA_W-1:0] cmdView;
  logic [DATA_W-1:0] startView;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  ind_reg_port_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .cmdView   (cmdView),
    .startView (startView),
    .strobe    (strobe)
  );

  ind_reg_port_dp #(.IMPL_WORDS(IMPL_WORDS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .wdataQ   (wdataQ),
    .rdataQ   (rdataQ)
  );

  always_comb begin
    case (busAddr)
      REG_CMD:   busRdata = cmdView;
      REG_START: busRdata = startView;
      REG_WDATA: busRdata = wdataQ;
      default:   busRdata = rdataQ;
    endcase
  end
endmodule

// File: tb/ind_reg_port_tb.sv
module ind_reg_port_tb;
  localparam int NW = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ind_reg_port #(.IMPL_WORDS(NW)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [31:0] pat(input int a, input int salt);
    return 32'h5A00_0000 ^ (32'(a) << 8) ^ 32'(a * 7 + salt) ^ (32'(salt) << 20);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic access(input bit rd, input int a, input logic [31:0] d);
    if (!rd) busWrite(2'd2, d);
    busWrite(2'd0, (rd ? 32'h100 : 32'h0) | 32'(a));
    busWrite(2'd1, 32'd1);
    busWrite(2'd1, 32'd0);
  endtask

  task automatic readInternal(input int a, output logic [31:0] d);
    access(1'b1, a, '0);
    busRead(2'd3, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      busRead(2'(r), v);
      check("R1 reset bus reg", v, 32'h0);
    end
    readInternal(1, v);
    check("R1 reset file", v, 32'h0);

    // R2 command field layout
    busWrite(2'd0, 32'hFFFF_FFFF);
    busRead(2'd0, v);
    check("R2 cmd readback", v, 32'h0000_013F);
    busWrite(2'd0, 32'h0000_0EC5);
    busRead(2'd0, v);
    check("R2 cmd partial", v, 32'h0000_0005);

    // R9 write-data readback
    busWrite(2'd2, 32'hDEAD_BEEF);
    busRead(2'd2, v);
    check("R9 wdata readback", v, 32'hDEAD_BEEF);
    busWrite(2'd1, 32'd0);

    // R5 protected sweep: writes ignored everywhere
    for (int a = 1; a < 64; a++) access(1'b0, a, pat(a, 1));
    for (int a = 0; a < 64; a++) begin
      readInternal(a, v);
      check("R5 locked write ignored", v, 32'h0);
    end

    // R6 unlock, R4 and R8 open sweep
    access(1'b0, 0, 32'hA500_0000);
    for (int a = 1; a < 64; a++) access(1'b0, a, pat(a, 2));
    for (int a = 0; a < 64; a++) begin
      readInternal(a, v);
      check((a >= 1 && a <= NW) ? "R4 stored word" : "R8 hole reads zero",
            v, (a >= 1 && a <= NW) ? pat(a, 2) : 32'h0);
    end

    // R7 read latency: old value right after start edge, new one a cycle later
    readInternal(2, v);
    busWrite(2'd0, 32'h100 | 32'd3);
    busWrite(2'd1, 32'd1);
    busRead(2'd3, v);
    check("R7 not yet updated", v, pat(2, 2));
    busRead(2'd3, v);
    check("R7 updated after one clock", v, pat(3, 2));
    busWrite(2'd1, 32'd0);

    // R3 held start does not relaunch
    busWrite(2'd0, 32'h100 | 32'd4);
    busWrite(2'd1, 32'd1);
    busWrite(2'd0, 32'h100 | 32'd1);
    busWrite(2'd1, 32'd1);
    busRead(2'd3, v);
    check("R3 held start no relaunch", v, pat(4, 2));
    busWrite(2'd1, 32'd0);
    busWrite(2'd1, 32'd0);
    busRead(2'd3, v);
    check("R3 zero write no launch", v, pat(4, 2));
    busRead(2'd1, v);
    check("R3 start readback", v, 32'h0);

    // R7 writes leave read data alone
    access(1'b0, 5, 32'h1234_5678);
    busRead(2'd3, v);
    check("R7 hold across write", v, pat(4, 2));
    readInternal(5, v);
    check("R4 overwrite", v, 32'h1234_5678);

    // R6 relock through address 0 with a wrong word
    access(1'b0, 0, 32'hA500_0001);
    access(1'b0, 1, 32'hCAFE_0001);
    readInternal(1, v);
    check("R6 relocked", v, pat(1, 2));
    access(1'b0, 0, 32'hA500_0000);
    access(1'b0, 1, 32'hCAFE_0001);
    readInternal(1, v2);
    check("R6 unlock again", v2, 32'hCAFE_0001);
    readInternal(0, v);
    check("R8 address zero reads zero", v, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule